// File: doc/BRIEF.md
# Random-Access Scan Array

This block is a bank of state flip-flops that a tester reaches one at a time by address, the way a memory is reached, instead of shifting every bit through one long chain. A small address register is loaded serially on its own clock. A decoder turns that address into a select that is one-hot, or all zero. In test mode only the selected flip-flop loads the shared scan-in bit, and a shared scan-out line always shows the value of the selected flip-flop. In functional mode every flip-flop captures its input from the surrounding combinational logic and feeds its output back to it.

A tester reads a cell by loading its address and looking at scan-out. It writes the cell by holding test mode high for one clock edge with the new bit on scan-in. Writing back the bit it just read makes the read non-destructive. A one-cycle acknowledge confirms each test-mode access that hit a real cell. The address is assumed to be held steady around each main-clock edge. The combinational logic around the array is not part of the block.

Top module: `ras_array`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, every bit of `func_q` and `ack` is cleared at that edge. While `rst_n` is low at a rising edge of `addr_clk`, the address register is cleared to 0 at that edge.
- R2: On each rising edge of `addr_clk` with `rst_n` high, the address register shifts one place toward its most significant end and takes `addr_sdi` into bit 0. After AW edges it therefore holds the last AW bits shifted, most significant bit first. Activity on `clk` never changes the address register.
- R3: When `test_mode` is 0 at a rising edge of `clk`, every bit of `func_q` takes the matching bit of `func_d`, whatever the address.
- R4: When `test_mode` is 1 at a rising edge of `clk` and the address is below NFF, the cell at that address takes `scan_in`. Every other cell keeps its value, and `func_d` has no effect.
- R5: While the address is below NFF, `scan_out` equals the bit of `func_q` at that address. The value follows an address change without waiting for a `clk` edge.
- R6: While the address is NFF or above, no cell is selected and `scan_out` is 0. A test-mode edge then changes no cell.
- R7: `ack` is 1 for exactly the one clock cycle after each rising edge of `clk` at which `test_mode` was 1 and the address was below NFF. It is 0 after every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock for the cells and the acknowledge |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| test_mode | input | 1 | 0 = functional capture, 1 = addressed test access |
| scan_in | input | 1 | Test data for the selected cell |
| scan_out | output | 1 | Value of the selected cell, 0 when no cell is selected |
| addr_clk | input | 1 | Shift clock of the address register |
| addr_sdi | input | 1 | Serial address bit, most significant bit first |
| func_d | input | NFF | Next-state inputs from the combinational logic |
| func_q | output | NFF | Cell outputs to the combinational logic |
| ack | output | 1 | One-cycle pulse after a test access to a real cell |

## Verification
`scan_out` depends on the address through logic alone, so it is due as soon as the serial address load has ended. The bench loads the address in the low phase of `clk` and checks `scan_out` before the next rising edge. `func_q` and `ack` each pass through one register, so they are due one edge after the stimulus. The bench drives each step at a falling edge and compares them at the next falling edge, against a bit model of the array that it updates from R3, R4 and R6. Every address, including the two with no cell, is swept with both scan-in values in test mode and with several patterns in functional mode.

// File: rtl/ras_pkg.sv
// Shared definitions for the random-access scan array.
// Assumes: NFF >= 2.
package ras_pkg;

    // Operating mode taken from the test control input.
    typedef enum logic {
        RAS_FUNC = 1'b0,
        RAS_TEST = 1'b1
    } ras_mode_e;

    // Address width needed to name every cell, at least one bit.
    function automatic int unsigned ras_addr_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ras_addr_shreg.sv
// Serial address register, loaded most significant bit first.
// Runs on its own clock; the main clock never touches it. Assumes the
// tester holds the address steady around each main-clock edge.
module ras_addr_shreg #(
    parameter int unsigned AW = 3
) (
    input  logic          addr_clk,
    input  logic          rst_n,
    input  logic          sdi,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_nxt;

    // Shift path: a one-bit register simply reloads.
    generate
        if (AW == 1) begin : g_one
            assign addr_nxt = sdi;
        end else begin : g_many
            assign addr_nxt = {addr[AW-2:0], sdi};
        end
    endgenerate

    // Address register: clear on reset, else shift by one place.
    always_ff @(posedge addr_clk) begin
        if (!rst_n) addr <= '0;
        else        addr <= addr_nxt;
    end

    // R2: the new bit lands in the least significant position.
    p_shift_in_r2: assert property (@(posedge addr_clk) disable iff (!rst_n)
        rst_n |=> (addr[0] == $past(sdi)));

endmodule

// File: rtl/ras_addr_decode.sv
// Address decoder: one select line per cell, all zero when the address
// is NFF or above. Purely combinational; the clock feeds only the checks.
module ras_addr_decode #(
    parameter int unsigned NFF = 6,
    parameter int unsigned AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    output logic [NFF-1:0] sel
);

    localparam logic [AW:0] LIMIT = (AW+1)'(NFF);

    // One comparator per cell.
    generate
        for (genvar i = 0; i < NFF; i++) begin : g_sel
            assign sel[i] = (addr == AW'(i));
        end
    endgenerate

    // R4: never more than one cell selected.
    p_onehot_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R6: an address without a cell selects nothing.
    p_no_sel_oob_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, addr} >= LIMIT) |-> (sel == '0));

endmodule

// File: rtl/ras_cell.sv
// One addressable state flip-flop. In functional mode it captures d.
// In test mode it loads si when selected and holds when not.
module ras_cell
    import ras_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tc,
    input  logic sel,
    input  logic si,
    input  logic d,
    output logic q
);

    ras_mode_e mode;

    assign mode = ras_mode_e'(tc);

    // Cell register: functional capture, or addressed scan load.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (mode == RAS_FUNC) q <= d;
        else if (sel)              q <= si;
    end

    // R3: functional mode always captures d.
    p_func_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tc |=> (q == $past(d)));

    // R4: a selected cell in test mode loads the scan bit.
    p_test_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && sel) |=> (q == $past(si)));

    // R4: an unselected cell in test mode keeps its value.
    p_hold_unsel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !sel) |=> $stable(q));

endmodule

// File: rtl/ras_readout.sv
// Shared scan-out: AND-OR of the select lines with the cell outputs.
// Gives 0 when no line is selected. Assumes the select is one-hot or zero.
module ras_readout #(
    parameter int unsigned NFF = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NFF-1:0] sel,
    input  logic [NFF-1:0] q,
    output logic           so
);

    // Pick the selected cell's value.
    assign so = |(sel & q);

    // R6: with nothing selected the line rests at 0.
    p_oob_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (so == 1'b0));

    // R5: a selected cell holding 1 shows up on the line.
    p_read_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel & q) != '0) |-> so);

endmodule

// File: rtl/ras_array.sv
// Random-access scan array top: address register, decoder, NFF cells,
// shared scan-out and the access acknowledge.
// Assumes the address is stable around each clk edge; the address clock
// is otherwise unrelated to clk.
module ras_array
    import ras_pkg::*;
#(
    parameter int unsigned NFF = 6,
    localparam int unsigned AW = ras_addr_width(NFF)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_mode,
    input  logic           scan_in,
    output logic           scan_out,
    input  logic           addr_clk,
    input  logic           addr_sdi,
    input  logic [NFF-1:0] func_d,
    output logic [NFF-1:0] func_q,
    output logic           ack
);

    logic [AW-1:0]  addr;
    logic [NFF-1:0] sel;

    ras_addr_shreg #(.AW(AW)) u_addr (
        .addr_clk (addr_clk),
        .rst_n    (rst_n),
        .sdi      (addr_sdi),
        .addr     (addr)
    );

    ras_addr_decode #(.NFF(NFF), .AW(AW)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .sel   (sel)
    );

    // One cell per state bit.
    generate
        for (genvar i = 0; i < NFF; i++) begin : g_cell
            ras_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .tc    (test_mode),
                .sel   (sel[i]),
                .si    (scan_in),
                .d     (func_d[i]),
                .q     (func_q[i])
            );
        end
    endgenerate

    ras_readout #(.NFF(NFF)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .q     (func_q),
        .so    (scan_out)
    );

    // Acknowledge: one pulse per test-mode edge that reached a cell.
    always_ff @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else        ack <= test_mode & (|sel);
    end

    // R7: an acknowledge always follows a test-mode edge.
    p_ack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(test_mode));

    // R7: a functional edge never leaves an acknowledge behind.
    p_ack_none_func_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> !ack);

endmodule

// File: tb/tb_ras_array.sv
`timescale 1ns/100ps
module tb_ras_array;

    localparam int NFF = 6;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           test_mode = 1'b0;
    logic           scan_in = 1'b0;
    logic           addr_clk = 1'b0;
    logic           addr_sdi = 1'b0;
    logic [NFF-1:0] func_d = '0;
    logic           scan_out;
    logic [NFF-1:0] func_q;
    logic           ack;

    int errors = 0;
    int checks = 0;
    logic [NFF-1:0] exp_q = '0;

    ras_array #(.NFF(NFF)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .scan_in   (scan_in),
        .scan_out  (scan_out),
        .addr_clk  (addr_clk),
        .addr_sdi  (addr_sdi),
        .func_d    (func_d),
        .func_q    (func_q),
        .ack       (ack)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [NFF-1:0] act,
                         input logic [NFF-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Serial address load, MSB first, 1 ns per bit (R2).
    task automatic load_addr(input int a);
        for (int b = AW - 1; b >= 0; b--) begin
            addr_sdi = a[b];
            #0.5 addr_clk = 1'b1;
            #0.5 addr_clk = 1'b0;
        end
    endtask

    // One access step, entered and left at a falling edge of clk.
    task automatic step(input int a, input logic t, input logic s,
                        input logic [NFF-1:0] d);
        logic [NFF-1:0] so_exp;
        test_mode = t;
        scan_in   = s;
        func_d    = d;
        load_addr(a);
        #0.5;
        if (a < NFF) begin
            so_exp = NFF'(exp_q[a]);
            check("R5 (R2 address order)", NFF'(scan_out), so_exp);
        end else begin
            check("R6 scan_out idle", NFF'(scan_out), '0);
        end
        @(negedge clk);
        if (!t)          exp_q = d;
        else if (a < NFF) exp_q[a] = s;
        if (!t)           check("R3 functional capture", func_q, exp_q);
        else if (a < NFF) check("R4 addressed write", func_q, exp_q);
        else              check("R6 no write out of range", func_q, exp_q);
        check("R7 ack", NFF'(ack), NFF'(t && (a < NFF)));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset on both clocks, with dirty inputs.
        func_d = '1;
        test_mode = 1'b1;
        scan_in = 1'b1;
        repeat (3) begin
            @(negedge clk);
            addr_sdi = 1'b1;
            #1 addr_clk = 1'b1;
            #1 addr_clk = 1'b0;
        end
        @(negedge clk);
        check("R1 func_q reset", func_q, '0);
        check("R1 ack reset", NFF'(ack), '0);
        check("R1 scan_out on address 0", NFF'(scan_out), '0);
        rst_n = 1'b1;
        exp_q = '0;

        // R3: functional capture, several patterns and addresses.
        step(0, 1'b0, 1'b0, 6'h2D);
        step(3, 1'b0, 1'b1, 6'h12);
        step(7, 1'b0, 1'b1, 6'h3F);
        step(5, 1'b0, 1'b0, 6'h21);

        // R4 R6 R7: test writes across every address, func_d ignored.
        for (int a = 0; a < 8; a++)
            step(a, 1'b1, a[0] ^ a[1], ~exp_q);

        // R5: non-destructive read back of every address.
        for (int a = 0; a < 8; a++)
            step(a, 1'b1, (a < NFF) ? exp_q[a] : 1'b1, 6'h15);

        // R4 R6: exhaustive sweep of address and scan bit.
        for (int a = 0; a < 8; a++)
            for (int s = 0; s < 2; s++)
                step(a, 1'b1, s[0], NFF'(a * 11 + s * 7));

        // R7: single access then functional edge, ack lasts one cycle.
        step(2, 1'b1, 1'b1, 6'h00);
        step(2, 1'b0, 1'b0, 6'h0A);
        step(6, 1'b1, 1'b1, 6'h0A);

        // R3 then R5: functional patterns read out through scan_out.
        for (int k = 0; k < 6; k++) begin
            step(k, 1'b0, 1'b1, NFF'(k * 37 + 5));
            step(k, 1'b1, exp_q[k], 6'h3F);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule